// File: doc/BRIEF.md
# DRAM Refresh and Power-Up Sequencer

This block keeps an asynchronous DRAM array refreshed and brings it up after reset. It first drives all strobes inactive for a long start-up pause. It then runs a fixed number of CAS-before-RAS cycles on its own and raises a ready flag. From that point an interval timer adds one owed refresh every refresh interval. Each owed refresh is served through a request/grant handshake with the access sequencer that otherwise owns the strobes.

When the sequencer grants the bus, the block takes over RAS, CAS and WE for one complete refresh cycle. That cycle is an idle lead-in, a setup phase, an active phase and a precharge. The block pulses a done flag in the last precharge clock and then gives the bus back. A mode input, sampled at the grant, selects CAS-before-RAS refresh or row-addressed refresh. The row-addressed form drives an internal row counter onto the address lines. Owed refreshes can pile up to a limit while the sequencer is busy, and an urgency flag shows when that limit is reached.

All timing is counted in clocks. The phase lengths are parameters chosen from the clock period so that every analogue minimum is met. With a 10 ns clock the defaults give a 20 ns lead-in, a 20 ns setup, a 70 ns active phase and a 50 ns precharge. That makes a 160 ns cycle, a 100 us pause and a 15.6 us interval.

Top module: `dram_refresh_ctrl`

## Requirements
- R1: For PAUSE_CLKS clocks after reset, `strobe_own` is 1, `ras_n` and `cas_n` are 1, `mem_ready`, `ref_req`, `ref_done` and `ref_urgent` are 0, and `bus_gnt` and `ror_mode` have no effect.
- R2: After the pause, INIT_CYCLES CAS-before-RAS cycles follow back to back without any grant. `mem_ready` rises on the clock after the last one's done pulse and then stays 1 until reset.
- R3: A refresh cycle starts at offset 0 and lasts T_LEAD+T_SETUP+T_ACT+T_PRE clocks. In CAS-before-RAS form, `cas_n` is 0 for offsets T_LEAD to T_LEAD+T_SETUP+T_ACT-1. `ras_n` is 0 for offsets T_LEAD+T_SETUP to T_LEAD+T_SETUP+T_ACT-1. Both are 1 at every other offset.
- R4: `we_n` is 1 at all times.
- R5: Once `mem_ready` is 1, one refresh becomes owed every REFI_CLKS clocks. The first one becomes owed REFI_CLKS clocks after `mem_ready` rises.
- R6: The count of owed refreshes saturates at MAX_PEND. `ref_urgent` is 1 exactly while the count equals MAX_PEND.
- R7: `ref_req` is 1 while `mem_ready` is 1, no refresh is running and at least one refresh is owed. A clock edge with `ref_req` and `bus_gnt` both 1 starts a refresh at offset 0 on the next cycle. `strobe_own` stays 1 until the cycle ends.
- R8: `ref_done` is 1 for exactly the last precharge clock of every refresh cycle. A granted cycle lowers the owed count by one at that edge.
- R9: `ror_mode` is sampled at the grant edge. Value 1 gives a row-addressed cycle, in which `cas_n` stays 1 and `ras_n` follows the R3 timing. After such a cycle the row counter on `row_addr` advances by one and wraps from 2^ROW_W-1 to 0.
- R10: `bus_gnt` has no effect while `ref_req` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ror_mode | input | 1 | 1 selects row-addressed refresh for the next granted cycle |
| bus_gnt | input | 1 | Sequencer has released the strobes |
| ref_req | output | 1 | A refresh is owed and the block wants the bus |
| ref_done | output | 1 | Last precharge clock of a refresh cycle |
| ref_urgent | output | 1 | Owed count at its limit |
| mem_ready | output | 1 | Start-up sequence complete |
| strobe_own | output | 1 | The block drives the strobes |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, held inactive |
| row_addr | output | ROW_W | Row counter for row-addressed refresh |

## Verification
Most internal faults show up at the ports within one refresh cycle. A wrong phase counter moves a strobe edge by at least one clock, and that is seen in the same cycle. A wrong owed-refresh count shows up later. It appears as a missing or extra `ref_req` after the next grant, or as `ref_urgent` at the wrong time, within a few refresh intervals. A row counter that skips or fails to wrap is visible on `row_addr` after the next row-addressed cycle. The bench drives long grant droughts, random grants with random mode changes, and a long row-addressed run that passes the wrap.

// File: rtl/dram_refresh_ctrl.sv
module dram_refresh_ctrl #(
  parameter int ROW_W       = 10,
  parameter int PAUSE_CLKS  = 10000,
  parameter int INIT_CYCLES = 8,
  parameter int REFI_CLKS   = 1560,
  parameter int MAX_PEND    = 8,
  parameter int T_LEAD      = 2,
  parameter int T_SETUP     = 2,
  parameter int T_ACT       = 7,
  parameter int T_PRE       = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ror_mode,
  input  logic             bus_gnt,
  output logic             ref_req,
  output logic             ref_done,
  output logic             ref_urgent,
  output logic             mem_ready,
  output logic             strobe_own,
  output logic             ras_n,
  output logic             cas_n,
  output logic             we_n,
  output logic [ROW_W-1:0] row_addr
);

  localparam int CW = $clog2(PAUSE_CLKS + T_LEAD + T_SETUP + T_ACT + T_PRE + 1);
  localparam int IW = $clog2(INIT_CYCLES + 1);
  localparam int TW = $clog2(REFI_CLKS + 1);
  localparam int PW = $clog2(MAX_PEND + 1);

  typedef enum logic [2:0] {ST_PAUSE, ST_IDLE, ST_LEAD, ST_SETUP, ST_ACT, ST_PRE} st_t;

  st_t              st;
  logic [CW-1:0]    cnt, len;
  logic [IW-1:0]    init_left;
  logic [TW-1:0]    tmr;
  logic [PW-1:0]    pend;
  logic             cbr, last, grab, dec, tick;

  always_comb begin
    case (st)
      ST_PAUSE: len = CW'(PAUSE_CLKS);
      ST_LEAD:  len = CW'(T_LEAD);
      ST_SETUP: len = CW'(T_SETUP);
      ST_ACT:   len = CW'(T_ACT);
      ST_PRE:   len = CW'(T_PRE);
      default:  len = CW'(1);
    endcase
  end

  assign last     = (cnt == len - CW'(1));
  assign ref_req  = mem_ready && (st == ST_IDLE) && (pend != '0);
  assign grab     = ref_req && bus_gnt;
  assign ref_done = (st == ST_PRE) && last;
  assign dec      = ref_done && mem_ready;
  assign tick     = mem_ready && (tmr == TW'(REFI_CLKS - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= ST_PAUSE;
      cnt       <= '0;
      cbr       <= 1'b1;
      init_left <= IW'(INIT_CYCLES);
      mem_ready <= 1'b0;
    end else begin
      cnt <= (st == ST_IDLE || last) ? '0 : cnt + CW'(1);
      case (st)
        ST_PAUSE: if (last) begin
          st  <= ST_LEAD;
          cbr <= 1'b1;
        end
        ST_IDLE: if (grab) begin
          st  <= ST_LEAD;
          cbr <= !ror_mode;
        end
        ST_LEAD:  if (last) st <= ST_SETUP;
        ST_SETUP: if (last) st <= ST_ACT;
        ST_ACT:   if (last) st <= ST_PRE;
        ST_PRE: if (last) begin
          if (!mem_ready) begin
            init_left <= init_left - IW'(1);
            if (init_left == IW'(1)) begin
              mem_ready <= 1'b1;
              st        <= ST_IDLE;
            end else begin
              st <= ST_LEAD;
            end
          end else begin
            st <= ST_IDLE;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tmr <= '0;
    end else if (mem_ready) begin
      tmr <= tick ? '0 : tmr + TW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend <= '0;
    end else if (tick && !dec) begin
      if (pend != PW'(MAX_PEND)) pend <= pend + PW'(1);
    end else if (dec && !tick) begin
      pend <= pend - PW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) row_addr <= '0;
    else if (dec && !cbr) row_addr <= row_addr + ROW_W'(1);
  end

  assign ref_urgent = (pend == PW'(MAX_PEND));
  assign strobe_own = (st != ST_IDLE);
  assign ras_n      = (st != ST_ACT);
  assign cas_n      = !(cbr && (st == ST_SETUP || st == ST_ACT));
  assign we_n       = 1'b1;

endmodule

// File: rtl/dram_refresh_ctrl_chk.sv
module dram_refresh_ctrl_chk #(
  parameter int ROW_W = 10
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bus_gnt,
  input logic             ref_req,
  input logic             ref_done,
  input logic             ref_urgent,
  input logic             mem_ready,
  input logic             strobe_own,
  input logic             ras_n,
  input logic             cas_n,
  input logic [ROW_W-1:0] row_addr
);

  AST_RAS_OWNED: assert property (@(posedge clk) disable iff (!rst_n)
    !ras_n |-> strobe_own);                                            // R3

  AST_CAS_OWNED: assert property (@(posedge clk) disable iff (!rst_n)
    !cas_n |-> strobe_own);                                            // R9

  AST_CAS_BEFORE_RAS: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(ras_n) && !cas_n) |-> $past(!cas_n));                       // R3

  AST_DONE_PRECHARGED: assert property (@(posedge clk) disable iff (!rst_n)
    ref_done |-> (ras_n && cas_n && strobe_own));                      // R8

  AST_NO_REQ_EARLY: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_ready |-> !ref_req);                                          // R1

  AST_READY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    mem_ready |=> mem_ready);                                          // R2

  AST_REQ_WAITS: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_req && !bus_gnt) |=> ref_req);                                // R7

  AST_GRANT_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_req && bus_gnt) |=> (strobe_own && !ref_req));                // R7

  AST_URGENT_OWED: assert property (@(posedge clk) disable iff (!rst_n)
    ref_urgent |-> (ref_req || strobe_own));                           // R6

  AST_ROW_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(row_addr) |-> ((row_addr - $past(row_addr)) == ROW_W'(1))); // R9

endmodule

bind dram_refresh_ctrl dram_refresh_ctrl_chk #(.ROW_W(ROW_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .bus_gnt(bus_gnt), .ref_req(ref_req),
  .ref_done(ref_done), .ref_urgent(ref_urgent), .mem_ready(mem_ready),
  .strobe_own(strobe_own), .ras_n(ras_n), .cas_n(cas_n), .row_addr(row_addr)
);

// File: tb/dram_refresh_ctrl_tb.sv
module dram_refresh_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int ROW_W = 10;
  localparam int PAUSE = 30;
  localparam int INIT  = 8;
  localparam int REFI  = 40;
  localparam int MAXP  = 8;
  localparam int TL = 2, TS = 2, TA = 7, TP = 5;
  localparam int TOT  = TL + TS + TA + TP;
  localparam int NROW = 1 << ROW_W;

  logic clk = 1'b0, rst_n = 1'b0, ror_mode = 1'b0, bus_gnt = 1'b0;
  logic ref_req, ref_done, ref_urgent, mem_ready, strobe_own, ras_n, cas_n, we_n;
  logic [ROW_W-1:0] row_addr;

  always #(CLK_PERIOD/2) clk = ~clk;

  dram_refresh_ctrl #(.ROW_W(ROW_W), .PAUSE_CLKS(PAUSE), .INIT_CYCLES(INIT),
    .REFI_CLKS(REFI), .MAX_PEND(MAXP), .T_LEAD(TL), .T_SETUP(TS), .T_ACT(TA),
    .T_PRE(TP)) dut_i (
    .clk(clk), .rst_n(rst_n), .ror_mode(ror_mode), .bus_gnt(bus_gnt),
    .ref_req(ref_req), .ref_done(ref_done), .ref_urgent(ref_urgent),
    .mem_ready(mem_ready), .strobe_own(strobe_own), .ras_n(ras_n),
    .cas_n(cas_n), .we_n(we_n), .row_addr(row_addr));

  int total = 0, bad = 0;
  int p_left = PAUSE, off = -1, cbr = 1, init_left = INIT, rdy = 0;
  int pend = 0, tmr = 0, row = 0;
  int max_pend_seen = 0, ror_cycles = 0;
  bit wrap_seen = 0, finished = 0;
  logic [ROW_W-1:0] prev_row = '0;

  always @(posedge clk) begin
    int tick, dec, tmr_n;
    if (!rst_n) begin
      p_left = PAUSE; off = -1; cbr = 1; init_left = INIT; rdy = 0;
      pend = 0; tmr = 0; row = 0;
    end else begin
      tick  = (rdy != 0 && tmr == REFI - 1) ? 1 : 0;
      tmr_n = (rdy != 0) ? (tmr + 1) % REFI : 0;
      dec   = 0;
      if (p_left > 0) begin
        p_left--;
        if (p_left == 0) begin off = 0; cbr = 1; end
      end else if (off >= 0) begin
        if (off == TOT - 1) begin
          if (rdy == 0) begin
            init_left--;
            if (init_left == 0) begin rdy = 1; off = -1; end
            else off = 0;
          end else begin
            dec = 1;
            if (cbr == 0) begin row = (row + 1) % NROW; ror_cycles++; end
            off = -1;
          end
        end else off++;
      end else if (rdy != 0 && pend > 0 && bus_gnt) begin
        off = 0;
        cbr = ror_mode ? 0 : 1;
      end
      pend = pend - dec + tick;
      if (pend > MAXP) pend = MAXP;
      if (pend > max_pend_seen) max_pend_seen = pend;
      tmr = tmr_n;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s t=%0t actual=%0d expected=%0d", tag, $time, act, exp);
    end
  endtask

  always @(negedge clk) begin
    int e_ras, e_cas, e_own, e_req, e_done, e_urg;
    if (!finished) begin
      e_own  = (p_left > 0 || off >= 0) ? 1 : 0;
      e_req  = (rdy != 0 && off < 0 && pend > 0) ? 1 : 0;
      e_ras  = (off >= TL + TS && off < TL + TS + TA) ? 0 : 1;
      e_cas  = (cbr != 0 && off >= TL && off < TL + TS + TA) ? 0 : 1;
      e_done = (off == TOT - 1) ? 1 : 0;
      e_urg  = (pend == MAXP) ? 1 : 0;
      chk(int'(ras_n) == e_ras, "R3 ras_n", int'(ras_n), e_ras);
      chk(int'(cas_n) == e_cas, "R9 cas_n", int'(cas_n), e_cas);
      chk(we_n == 1'b1, "R4 we_n", int'(we_n), 1);
      chk(int'(strobe_own) == e_own, "R1 strobe_own", int'(strobe_own), e_own);
      chk(int'(ref_req) == e_req, "R7 ref_req", int'(ref_req), e_req);
      chk(int'(ref_done) == e_done, "R8 ref_done", int'(ref_done), e_done);
      chk(int'(ref_urgent) == e_urg, "R6 ref_urgent", int'(ref_urgent), e_urg);
      chk(int'(mem_ready) == rdy, "R2 mem_ready", int'(mem_ready), rdy);
      chk(int'(row_addr) == row, "R9 row_addr", int'(row_addr), row);
      if (prev_row == ROW_W'(NROW - 1) && row_addr == '0) wrap_seen = 1;
      prev_row = row_addr;
    end
  end

  initial begin
    logic [15:0] lfsr = 16'hACE1;
    repeat (3) @(negedge clk);
    chk(strobe_own && ras_n && cas_n && !mem_ready && !ref_req, "R1 reset state",
        int'({strobe_own, ras_n, cas_n, mem_ready, ref_req}), 5'b11100);
    @(negedge clk) rst_n = 1'b1;
    bus_gnt = 1'b1; ror_mode = 1'b1;  // R10: ignored during pause and start-up
    repeat (PAUSE + INIT * TOT + 2) @(negedge clk);
    chk(mem_ready == 1'b1, "R2 ready after start-up", int'(mem_ready), 1);
    chk(row_addr == '0, "R10 start-up used CAS-before-RAS only", int'(row_addr), 0);
    ror_mode = 1'b0;
    repeat (600) @(negedge clk);
    bus_gnt = 1'b0;
    repeat (500) @(negedge clk);
    chk(ref_urgent == 1'b1, "R6 saturated after drought", int'(ref_urgent), 1);
    chk(max_pend_seen == MAXP, "R6 owed count limit", max_pend_seen, MAXP);
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      bus_gnt  = lfsr[0] & lfsr[3];
      ror_mode = lfsr[5];
    end
    bus_gnt = 1'b1; ror_mode = 1'b1;
    repeat (45000) @(negedge clk);
    chk(wrap_seen, "R9 row counter wrapped", int'(wrap_seen), 1);
    chk(ror_cycles > NROW, "R5 row-addressed cycle count", ror_cycles, NROW + 1);
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    finished = 1;
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule